// File: doc/BRIEF.md
# Presettable Chainable Digit Counter

A four-bit synchronous counter that advances on the rising clock edge. One build parameter chooses decimal counting (0 through 9) or full binary counting (0 through 15). A second build parameter chooses whether the active-low clear takes effect at the next clock edge or at once. The counter can be preset from a four-bit data input, and two count enables gate the increment: a broadside enable shared by all stages, and a ripple enable passed down from the previous stage.

The terminal flag is raised when the ripple enable is high and the counter is at its last state. That flag drives the ripple enable of the next stage. Identical instances therefore form multi-digit counters with no gating between them. All stages share the clock and the broadside enable, and the whole chain advances on one edge.

A decimal counter can be preset with a code from 10 to 15. From such a code it returns to the legal range within two counting edges, and it never raises the terminal flag while outside that range.

Top module: `sync_digit_counter`

## Requirements
- R1: With a synchronous clear (ASYNC_CLR=0), a low `clr_n` at a rising edge sets `count` to 0. It overrides load and both enables, and without a clock edge it has no effect.
- R2: With an asynchronous clear (ASYNC_CLR=1), a low `clr_n` sets `count` to 0 at once and holds it there, whatever the clock and the other inputs do.
- R3: With clear inactive, a low `load_n` at a rising edge copies `par_d` into `count`, whatever the enables are. Every value from 0 to 15 is accepted, including 10 to 15 in decimal mode.
- R4: With clear and load inactive and both `en_par` and `en_trk` high, each rising edge advances `count` by one. From the last state (9 in decimal mode, 15 in binary mode) it goes to 0.
- R5: With clear and load inactive, a low on either `en_par` or `en_trk` keeps `count` unchanged across the edge.
- R6: `tc` is 1 exactly when `en_trk` is 1 and `count` equals the last state (binary 1001 in decimal mode, 1111 in binary mode). It follows `en_trk` without waiting for a clock.
- R7: In decimal mode, counting edges move the out-of-range codes along the fixed paths 10→11→6, 12→13→4 and 14→15→2. Any preset code therefore reaches 0..9 within two counting edges.
- R8: In decimal mode, `tc` stays 0 while `count` holds any code from 10 to 15.
- R9: With an asynchronous clear, releasing `clr_n` between edges does not advance the counter. The first increment happens at the next rising edge where counting is enabled.
- R10: Three decimal stages chained through `tc` into the next `en_trk`, with a shared `en_par`, go from 999 to 000 on a single edge and carry correctly between digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes occur on its rising edge except an asynchronous clear |
| clr_n | input | 1 | Active-low clear, synchronous or asynchronous by parameter |
| load_n | input | 1 | Active-low parallel preset |
| par_d | input | WIDTH | Preset value |
| en_par | input | 1 | Broadside count enable |
| en_trk | input | 1 | Ripple count enable; also qualifies `tc` |
| count | output | WIDTH | Current counter state |
| tc | output | 1 | Terminal flag for chaining into the next stage |

## Verification
The hardest states to reach are the decimal out-of-range codes 10 to 15. Counting never enters them, so they appear only through a preset. The stimulus presets each of the six codes and then applies two counting edges, checking each step of the recovery path and the absence of `tc` along the way. Random phases add presets at a lower rate, so some out-of-range codes also meet holds, clears and further presets. The 999-to-000 carry of a three-stage chain needs every digit at its last state at once, so that chain is preset to 999 before a single counting edge is applied.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_COUNT = 2'd1,
      ACT_LOAD  = 2'd2,
      ACT_CLEAR = 2'd3
   } sdc_act_e;
endpackage

// File: rtl/sdc_step.sv
`timescale 1ns/1ps
// Successor state for one counting edge.
module sdc_step #(
   parameter int WIDTH   = 4,
   parameter bit DECIMAL = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);
   generate
      if (DECIMAL) begin : g_dec
         always_comb begin
            case (cur)
               WIDTH'(9):  nxt = '0;
               WIDTH'(10): nxt = WIDTH'(11);
               WIDTH'(11): nxt = WIDTH'(6);
               WIDTH'(12): nxt = WIDTH'(13);
               WIDTH'(13): nxt = WIDTH'(4);
               WIDTH'(14): nxt = WIDTH'(15);
               WIDTH'(15): nxt = WIDTH'(2);
               default:    nxt = cur + WIDTH'(1);
            endcase
         end
      end else begin : g_bin
         assign nxt = cur + WIDTH'(1);
      end
   endgenerate
endmodule

// File: rtl/sdc_terminal.sv
`timescale 1ns/1ps
// Terminal-state decode, qualified by the ripple enable.
module sdc_terminal #(
   parameter int WIDTH   = 4,
   parameter bit DECIMAL = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             en_trk,
   output logic             tc
);
   localparam logic [WIDTH-1:0] LAST = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};
   assign tc = en_trk & (cur == LAST);
endmodule

// File: rtl/sdc_mode_sel.sv
`timescale 1ns/1ps
// Picks the edge action by priority: clear, load, count, hold.
module sdc_mode_sel
   import sdc_pkg::*;
(
   input  logic     sclr_n,
   input  logic     load_n,
   input  logic     en_par,
   input  logic     en_trk,
   output sdc_act_e act
);
   always_comb begin
      if (!sclr_n)              act = ACT_CLEAR;
      else if (!load_n)         act = ACT_LOAD;
      else if (en_par & en_trk) act = ACT_COUNT;
      else                      act = ACT_HOLD;
   end
endmodule

// File: rtl/sync_digit_counter.sv
`timescale 1ns/1ps
module sync_digit_counter
   import sdc_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit DECIMAL   = 1'b1,
   parameter bit ASYNC_CLR = 1'b0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic [WIDTH-1:0] par_d,
   input  logic             en_par,
   input  logic             en_trk,
   output logic [WIDTH-1:0] count,
   output logic             tc
);
   generate
      if (WIDTH < 1) begin : g_chk_w
         $error("sync_digit_counter: WIDTH must be at least 1");
      end
      if (DECIMAL && WIDTH != 4) begin : g_chk_dec
         $error("sync_digit_counter: decimal mode needs WIDTH of 4");
      end
   endgenerate

   logic             sclr_n;
   logic [WIDTH-1:0] step_val;
   sdc_act_e         act;
   logic [WIDTH-1:0] state_q;

   sdc_step #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) step_i (
      .cur (state_q),
      .nxt (step_val)
   );

   sdc_terminal #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) term_i (
      .cur    (state_q),
      .en_trk (en_trk),
      .tc     (tc)
   );

   sdc_mode_sel sel_i (
      .sclr_n (sclr_n),
      .load_n (load_n),
      .en_par (en_par),
      .en_trk (en_trk),
      .act    (act)
   );

   generate
      if (ASYNC_CLR) begin : g_aclr
         assign sclr_n = 1'b1;
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
               state_q <= '0;
            end else begin
               case (act)
                  ACT_LOAD:  state_q <= par_d;
                  ACT_COUNT: state_q <= step_val;
                  default:   state_q <= state_q;
               endcase
            end
         end
      end else begin : g_sclr
         assign sclr_n = clr_n;
         always_ff @(posedge clk) begin
            case (act)
               ACT_CLEAR: state_q <= '0;
               ACT_LOAD:  state_q <= par_d;
               ACT_COUNT: state_q <= step_val;
               default:   state_q <= state_q;
            endcase
         end
      end
   endgenerate

   assign count = state_q;
endmodule

// File: rtl/sdc_checker.sv
`timescale 1ns/1ps
module sdc_checker #(
   parameter int WIDTH     = 4,
   parameter bit DECIMAL   = 1'b1,
   parameter bit ASYNC_CLR = 1'b0
) (
   input logic             clk,
   input logic             clr_n,
   input logic             load_n,
   input logic [WIDTH-1:0] par_d,
   input logic             en_par,
   input logic             en_trk,
   input logic [WIDTH-1:0] count,
   input logic             tc
);
   localparam logic [WIDTH-1:0] LAST = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] NINE = WIDTH'(9);

   p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> count == $past(par_d));

   p_wrap_r4: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && en_par && en_trk && count == LAST) |=> count == '0);

   p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !(en_par && en_trk)) |=> $stable(count));

   p_tc_on_r6: assert property (@(posedge clk) disable iff (!clr_n)
      (en_trk && count == LAST) |-> tc);

   p_tc_off_r6: assert property (@(posedge clk) disable iff (!clr_n)
      (count != LAST || !en_trk) |-> !tc);

   generate
      if (DECIMAL) begin : g_dec
         p_first_step_r7: assert property (@(posedge clk) disable iff (!clr_n)
            (count > NINE && !count[0] && load_n && en_par && en_trk)
               |=> (count > NINE && count[0]));
         p_second_step_r7: assert property (@(posedge clk) disable iff (!clr_n)
            (count > NINE && count[0] && load_n && en_par && en_trk)
               |=> count <= NINE);
         p_no_tc_r8: assert property (@(posedge clk) disable iff (!clr_n)
            (count > NINE) |-> !tc);
      end
      if (ASYNC_CLR) begin : g_async
         p_aclr_r2: assert property (@(posedge clk)
            !clr_n |-> count == '0);
      end else begin : g_sync
         p_sclr_r1: assert property (@(posedge clk)
            !clr_n |=> count == '0);
      end
   endgenerate
endmodule

bind sync_digit_counter sdc_checker #(
   .WIDTH(WIDTH), .DECIMAL(DECIMAL), .ASYNC_CLR(ASYNC_CLR)
) chk_i (
   .clk(clk), .clr_n(clr_n), .load_n(load_n), .par_d(par_d),
   .en_par(en_par), .en_trk(en_trk), .count(count), .tc(tc)
);

// File: tb/sync_digit_counter_tb_top.sv
`timescale 1ns/1ps
module sync_digit_counter_tb_top;
   logic       clk = 1'b0;
   logic       clr_s = 1'b1, clr_a = 1'b1, c_clr = 1'b1;
   logic       ld_n = 1'b1, enp = 1'b0, ent = 1'b0;
   logic [3:0] d = 4'd0;
   logic [3:0] q_s, q_a;
   logic       tc_s, tc_a;
   logic       c_ld = 1'b1, c_enp = 1'b0, c_ent0 = 1'b0;
   logic [3:0] c_d = 4'd0;
   logic [3:0] q0, q1, q2;
   logic       tc0, tc1, tc2;
   logic [3:0] m_s = 4'd0, m_a = 4'd0;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   sync_digit_counter #(.WIDTH(4), .DECIMAL(1'b1), .ASYNC_CLR(1'b0)) dut_i (
      .clk(clk), .clr_n(clr_s), .load_n(ld_n), .par_d(d), .en_par(enp),
      .en_trk(ent), .count(q_s), .tc(tc_s));

   sync_digit_counter #(.WIDTH(4), .DECIMAL(1'b0), .ASYNC_CLR(1'b1)) bin_i (
      .clk(clk), .clr_n(clr_a), .load_n(ld_n), .par_d(d), .en_par(enp),
      .en_trk(ent), .count(q_a), .tc(tc_a));

   sync_digit_counter #(.WIDTH(4), .DECIMAL(1'b1), .ASYNC_CLR(1'b0)) ch0_i (
      .clk(clk), .clr_n(c_clr), .load_n(c_ld), .par_d(c_d), .en_par(c_enp),
      .en_trk(c_ent0), .count(q0), .tc(tc0));
   sync_digit_counter #(.WIDTH(4), .DECIMAL(1'b1), .ASYNC_CLR(1'b0)) ch1_i (
      .clk(clk), .clr_n(c_clr), .load_n(c_ld), .par_d(c_d), .en_par(c_enp),
      .en_trk(tc0), .count(q1), .tc(tc1));
   sync_digit_counter #(.WIDTH(4), .DECIMAL(1'b1), .ASYNC_CLR(1'b0)) ch2_i (
      .clk(clk), .clr_n(c_clr), .load_n(c_ld), .par_d(c_d), .en_par(c_enp),
      .en_trk(tc1), .count(q2), .tc(tc2));

   function automatic logic [3:0] ref_next(logic [3:0] q, bit dec, logic ldn,
                                           logic [3:0] dd, logic ep, logic et);
      if (!ldn) return dd;
      if (!(ep && et)) return q;
      if (!dec) return q + 4'd1;
      case (q)
         4'd9:  return 4'd0;
         4'd10: return 4'd11;
         4'd11: return 4'd6;
         4'd12: return 4'd13;
         4'd13: return 4'd4;
         4'd14: return 4'd15;
         4'd15: return 4'd2;
         default: return q + 4'd1;
      endcase
   endfunction

   function automatic logic ref_tc(logic [3:0] q, bit dec, logic et);
      return et && (q == (dec ? 4'd9 : 4'd15));
   endfunction

   function automatic string edge_tag(logic clr, logic ldn, logic ep, logic et,
                                      logic [3:0] q, bit dec);
      if (!clr) return "R1";
      if (!ldn) return "R3";
      if (ep && et) return (dec && q > 4'd9) ? "R7" : "R4";
      return "R5";
   endfunction

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // One edge: inputs were set after the falling edge; compare just after rising edge.
   task automatic step();
      string ts, ta;
      ts = edge_tag(clr_s, ld_n, enp, ent, m_s, 1'b1);
      ta = (!clr_a) ? "R2" : edge_tag(1'b1, ld_n, enp, ent, m_a, 1'b0);
      @(posedge clk);
      m_s = clr_s ? ref_next(m_s, 1'b1, ld_n, d, enp, ent) : 4'd0;
      m_a = clr_a ? ref_next(m_a, 1'b0, ld_n, d, enp, ent) : 4'd0;
      #1;
      check({ts, " dec count"}, q_s, m_s);
      check({ta, " bin count"}, q_a, m_a);
      check((m_s > 4'd9) ? "R8 dec tc" : "R6 dec tc", tc_s, ref_tc(m_s, 1'b1, ent));
      check("R6 bin tc", tc_a, ref_tc(m_a, 1'b0, ent));
      @(negedge clk);
   endtask

   initial begin
      #1_600_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0161));
      #2;
      clr_s = 1'b0; clr_a = 1'b0; c_clr = 1'b0;
      m_a = 4'd0;
      step();
      ld_n = 1'b0; d = 4'd7; enp = 1'b1; ent = 1'b1;   // R1: clear beats load
      step();
      check("R1 reset state", q_s, 0);
      check("R2 reset state", q_a, 0);

      // R9: release async clear mid-cycle with counting enabled
      ld_n = 1'b1; clr_s = 1'b1; c_clr = 1'b1;
      #1 clr_a = 1'b1;
      #1 check("R9 no count at release", q_a, 0);
      step();
      check("R9 first increment", q_a, 1);

      // R2: async clear with no clock edge
      ld_n = 1'b0; d = 4'd12;
      step();
      #1 clr_a = 1'b0;
      #1 check("R2 immediate clear", q_a, 0);
      m_a = 4'd0;
      step();
      clr_a = 1'b1;

      // R7/R8: every out-of-range decimal preset, then two counting edges
      for (int v = 10; v <= 15; v++) begin
         ld_n = 1'b0; d = 4'(v); enp = 1'b0; ent = 1'b1;
         step();
         ld_n = 1'b1; enp = 1'b1;
         step();
         step();
         check("R7 legal after two edges", int'(q_s <= 4'd9), 1);
      end

      // R4/R6: binary wrap from 15
      ld_n = 1'b0; d = 4'd15; enp = 1'b1; ent = 1'b1;
      step();
      check("R6 bin tc at 15", tc_a, 1);
      ld_n = 1'b1;
      step();
      check("R4 bin wrap", q_a, 0);

      // R5: either enable low holds
      enp = 1'b0;
      step();
      enp = 1'b1; ent = 1'b0;
      step();

      // random phase
      for (int i = 0; i < 1200; i++) begin
         ld_n  = ($urandom % 8) != 0;
         enp   = ($urandom % 4) != 0;
         ent   = ($urandom % 4) != 0;
         d     = 4'($urandom % 16);
         clr_s = ($urandom % 32) != 0;
         clr_a = 1'b1;
         if (($urandom % 32) == 0) begin
            #1 clr_a = 1'b0;
            #1 check("R2 mid-cycle clear", q_a, 0);
            m_a = 4'd0;
         end
         step();
      end
      clr_s = 1'b1; clr_a = 1'b1;

      // R10: three-digit decimal chain
      c_clr = 1'b1; c_ld = 1'b0; c_d = 4'd9; c_enp = 1'b1; c_ent0 = 1'b1;
      step();
      check("R10 preset 999", {q2, q1, q0} == 12'h999, 1);
      check("R10 carry out at 999", tc2, 1);
      c_ld = 1'b1;
      step();
      check("R10 wrap to 000", {q2, q1, q0} == 12'h000, 1);
      for (int k = 0; k < 10; k++) step();
      check("R10 carry into tens", {q2, q1, q0} == 12'h010, 1);
      c_ent0 = 1'b0;
      step();
      check("R10 hold with ripple enable low", {q2, q1, q0} == 12'h010, 1);
      c_ent0 = 1'b1; c_enp = 1'b0;
      step();
      check("R10 hold with broadside enable low", {q2, q1, q0} == 12'h010, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule